// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Controller

This block is the transmit half of a small memory-mapped Ethernet MAC. Software fills one of two frame buffers over a 32-bit word-addressed register bus, writes the frame length, and then writes that buffer's control word. Each control word carries a command pair. With start set and program clear, the buffer is sent as a byte stream. With both start and program set, the first six bytes of the buffer become the station MAC address. Preamble, FCS and the PHY are handled downstream.

Each buffer has a start/busy flag, a program flag and a local interrupt enable. Start and program stay set while the command is in progress and clear themselves when it completes. A single transmit engine serves the two buffers one at a time, so frames never interleave on the output. The engine raises a shared one-cycle interrupt for each completion whose buffer has its local enable set, but only while the global interrupt enable bit is set.

Top module: `frame_tx_dualbuf`

## Requirements
- R1: After reset both control words, both length registers and the global enable read 0, `tx_valid` and `irq` are low, and `station_mac` equals the `MAC_RESET` parameter.
- R2: Buffer words that are not registers read back as last written. Frame byte k of a buffer is held in buffer word k/4 at bits [8*(k%4)+7 : 8*(k%4)].
- R3: Buffer b occupies word addresses b*BUF_WORDS up to b*BUF_WORDS+BUF_WORDS-1. Within it, word BUF_WORDS-3 is the length register, which keeps its low log2(4*BUF_WORDS) bits. Word BUF_WORDS-1 is the control word, with S at bit 0, P at bit 1 and I at bit 3; all other control bits read 0. The global enable sits at word BUF_WORDS-2 of buffer 0 only, and only its bit 31 is kept. The same word in buffer 1 is plain storage.
- R4: Writing a control word with S=1 and P=0 streams exactly length bytes of that buffer in byte order on `tx_data`. `tx_last` is set only on the final byte. Each byte stays offered until `tx_ready` takes it.
- R5: Writing S=1 and P=1 loads `station_mac` with buffer bytes 0..5, byte 0 at bits [47:40] and byte 5 at bits [7:0]. No bytes are streamed.
- R6: S (and P for an address load) read 1 from the write until the command completes, then read 0. The I bit is kept.
- R7: A control write with S=0 stores only the I bit and starts nothing.
- R8: A control write to a buffer whose S bit is set is ignored entirely.
- R9: Each completion gives a one-cycle `irq` pulse when the buffer's I bit and global enable bit 31 are both set; otherwise no pulse.
- R10: A length of 0 streams nothing but still completes and can interrupt.
- R11: A command on one buffer issued while the other is streaming waits, and its frame follows the first without interleaving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register/buffer write strobe |
| bus_re | input | 1 | Read strobe; data returned the next cycle |
| bus_addr | input | log2(2*BUF_WORDS) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Byte offered |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| station_mac | output | 48 | Station MAC address |
| irq | output | 1 | Shared completion interrupt pulse |

## Verification
The bench builds the block with BUF_WORDS of 16 and a non-zero MAC_RESET. The small buffers make the largest frame (52 bytes) and the zero-length frame common under random lengths. They also let every register offset, including the plain-storage word in buffer 1, be hit directly. Holding `tx_ready` low keeps a buffer busy long enough to probe ignored writes and queued commands on the other buffer.

// File: rtl/frame_tx_dualbuf.sv
module frame_tx_dualbuf #(
  parameter int          BUF_WORDS = 512,
  parameter logic [47:0] MAC_RESET = 48'h0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_we,
  input  logic                             bus_re,
  input  logic [$clog2(2*BUF_WORDS)-1:0]   bus_addr,
  input  logic [31:0]                      bus_wdata,
  output logic [31:0]                      bus_rdata,
  output logic [7:0]                       tx_data,
  output logic                             tx_valid,
  output logic                             tx_last,
  input  logic                             tx_ready,
  output logic [47:0]                      station_mac,
  output logic                             irq
);
  localparam int WI = $clog2(BUF_WORDS);
  localparam int AW = WI + 1;
  localparam int LW = WI + 2;
  localparam logic [WI-1:0] LEN_OFS = WI'(BUF_WORDS - 3);
  localparam logic [WI-1:0] GIE_OFS = WI'(BUF_WORDS - 2);
  localparam logic [WI-1:0] CTL_OFS = WI'(BUF_WORDS - 1);

  logic [31:0]   mem [2*BUF_WORDS];
  logic [LW-1:0] len_q [2];
  logic          gie_q;
  logic [1:0]    s_q, p_q, i_q;
  logic          run_q, cur_q, irq_q;
  logic [LW-1:0] cnt_q, elen_q;
  logic [47:0]   mac_q;

  wire          sel_b  = bus_addr[AW-1];
  wire [WI-1:0] ofs    = bus_addr[WI-1:0];
  wire          is_len = (ofs == LEN_OFS);
  wire          is_ctl = (ofs == CTL_OFS);
  wire          is_gie = (ofs == GIE_OFS) && !sel_b;
  wire          is_reg = is_len | is_ctl | is_gie;

  wire          pick    = !run_q && (|s_q);
  wire          pb      = s_q[0] ? 1'b0 : 1'b1;
  wire          quick   = pick && (p_q[pb] || len_q[pb] == '0);
  wire          xfer    = tx_valid && tx_ready;
  wire          end_str = xfer && tx_last;
  wire          fin     = quick || end_str;
  wire          fin_b   = run_q ? cur_q : pb;

  wire [31:0]   cur_word = mem[{cur_q, cnt_q[LW-1:2]}];
  wire [31:0]   mw0      = mem[{pb, WI'(0)}];
  wire [31:0]   mw1      = mem[{pb, WI'(1)}];

  assign tx_valid    = run_q;
  assign tx_data     = cur_word[8*cnt_q[1:0] +: 8];
  assign tx_last     = run_q && (cnt_q == elen_q - 1'b1);
  assign station_mac = mac_q;
  assign irq         = irq_q;

  always_ff @(posedge clk)
    if (bus_we && !is_reg) mem[bus_addr] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_q <= '0; p_q <= '0; i_q <= '0;
      len_q[0] <= '0; len_q[1] <= '0;
      gie_q <= 1'b0;
    end else begin
      if (bus_we && is_gie) gie_q <= bus_wdata[31];
      for (int b = 0; b < 2; b++) begin
        if (bus_we && is_len && sel_b == 1'(b)) len_q[b] <= bus_wdata[LW-1:0];
        if (fin && fin_b == 1'(b)) begin
          s_q[b] <= 1'b0;
          p_q[b] <= 1'b0;
        end else if (bus_we && is_ctl && sel_b == 1'(b) && !s_q[b]) begin
          s_q[b] <= bus_wdata[0];
          p_q[b] <= bus_wdata[0] & bus_wdata[1];
          i_q[b] <= bus_wdata[3];
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q  <= 1'b0;
      cur_q  <= 1'b0;
      cnt_q  <= '0;
      elen_q <= '0;
      irq_q  <= 1'b0;
      mac_q  <= MAC_RESET;
    end else begin
      irq_q <= fin && i_q[fin_b] && gie_q;
      if (pick) begin
        if (p_q[pb])
          mac_q <= {mw0[7:0], mw0[15:8], mw0[23:16], mw0[31:24], mw1[7:0], mw1[15:8]};
        if (!quick) begin
          run_q  <= 1'b1;
          cur_q  <= pb;
          cnt_q  <= '0;
          elen_q <= len_q[pb];
        end
      end else if (xfer) begin
        cnt_q <= cnt_q + 1'b1;
        if (tx_last) run_q <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (bus_re) begin
      if (is_gie)      bus_rdata <= {gie_q, 31'b0};
      else if (is_len) bus_rdata <= 32'(len_q[sel_b]);
      else if (is_ctl) bus_rdata <= {28'b0, i_q[sel_b], 1'b0, p_q[sel_b], s_q[sel_b]};
      else             bus_rdata <= mem[bus_addr];
    end

  a_r4_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_last));
  a_r9_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie_q));
  a_r6_stream_owner_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> s_q[cur_q] && !p_q[cur_q]);
  a_r5_p_only_with_s: assert property (@(posedge clk) disable iff (!rst_n)
    (p_q & ~s_q) == 2'b00);
endmodule

// File: tb/sim_frame_tx_dualbuf.sv
module sim_frame_tx_dualbuf;
  localparam int BW   = 16;
  localparam int AW   = $clog2(2*BW);
  localparam int MAXB = (BW - 3) * 4;
  localparam logic [47:0] MRST = 48'h02AA_BBCC_DD01;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0, bus_re = 0, tx_ready = 1;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, irq;
  logic [47:0] station_mac;

  frame_tx_dualbuf #(.BUF_WORDS(BW), .MAC_RESET(MRST)) u0 (.*);

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  int ready_mode = 0;
  logic [7:0] sh [2][BW*4];
  logic [7:0] got [8192]; bit got_last [8192]; int got_n = 0;
  logic [7:0] exp_b [8192]; bit exp_last [8192]; int exp_n = 0;
  int irq_cnt = 0, irq_exp = 0;
  bit gie_m = 0;

  always @(posedge clk) begin
    #1;
    if (ready_mode == 0) tx_ready = 1;
    else if (ready_mode == 1) tx_ready = ($urandom % 3) != 0;
    else tx_ready = 0;
  end

  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      got[got_n] = tx_data; got_last[got_n] = tx_last; got_n++;
    end
    if (irq) irq_cnt++;
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [AW-1:0] adr(bit b, int w);
    return {b, (AW-1)'(w)};
  endfunction

  task automatic bwr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic brd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_re = 1; bus_addr = a;
    @(negedge clk); bus_re = 0; d = bus_rdata;
  endtask

  task automatic fill(bit b, int n);
    for (int w = 0; w < (n + 3) / 4; w++) begin
      logic [31:0] d;
      d = $urandom;
      for (int k = 0; k < 4; k++) sh[b][4*w+k] = d[8*k +: 8];
      bwr(adr(b, w), d);
    end
  endtask

  task automatic start(bit b, int len, bit iv, bit prog);
    if (!prog) begin
      for (int k = 0; k < len; k++) begin
        exp_b[exp_n] = sh[b][k]; exp_last[exp_n] = (k == len - 1); exp_n++;
      end
    end
    if (iv && gie_m) irq_exp++;
    bwr(adr(b, BW - 3), 32'(len));
    bwr(adr(b, BW - 1), {28'b0, iv, 1'b0, prog, 1'b1});
  endtask

  task automatic wait_idle(bit b);
    logic [31:0] d;
    for (int t = 0; t < 3000; t++) begin
      brd(adr(b, BW - 1), d);
      if (!d[0]) break;
    end
    chk(d[1:0] == 2'b00, "R6 S/P self-clear", d, 0);
    repeat (3) @(negedge clk);
  endtask

  int chk_from = 0;
  task automatic cmp_frames(string tag);
    int bad = 0;
    chk(got_n == exp_n, {tag, " byte count"}, got_n, exp_n);
    for (int i = chk_from; i < exp_n && i < got_n; i++)
      if (got[i] !== exp_b[i] || got_last[i] !== exp_last[i]) bad++;
    chk(bad == 0, {tag, " bytes/last"}, bad, 0);
    chk(irq_cnt == irq_exp, "R9 irq pulses", irq_cnt, irq_exp);
    chk_from = exp_n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [47:0] m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(tx_valid == 0 && irq == 0, "R1 outputs idle", {tx_valid, irq}, 0);
    chk(station_mac == MRST, "R1 mac reset", station_mac, MRST);
    brd(adr(0, BW - 1), d); chk(d == 0, "R1 ctrl0", d, 0);
    brd(adr(1, BW - 1), d); chk(d == 0, "R1 ctrl1", d, 0);
    brd(adr(1, BW - 3), d); chk(d == 0, "R1 len1", d, 0);
    brd(adr(0, BW - 2), d); chk(d == 0, "R1 gie", d, 0);
    // R2 storage and lane readback
    bwr(adr(1, 3), 32'hDEAD_BEEF); brd(adr(1, 3), d);
    chk(d == 32'hDEAD_BEEF, "R2 word readback", d, 32'hDEAD_BEEF);
    bwr(adr(1, BW - 2), 32'h1234_5678); brd(adr(1, BW - 2), d);
    chk(d == 32'h1234_5678, "R3 buf1 plain word", d, 32'h1234_5678);
    // R3 register widths
    bwr(adr(0, BW - 3), 32'hFFFF_FFFF); brd(adr(0, BW - 3), d);
    chk(d == 32'(4*BW - 1), "R3 len width", d, 4*BW - 1);
    bwr(adr(0, BW - 2), 32'hFFFF_FFFF); brd(adr(0, BW - 2), d);
    chk(d == 32'h8000_0000, "R3 gie bit31", d, 32'h8000_0000);
    gie_m = 1;
    // R7 S=0 write
    bwr(adr(1, BW - 1), 32'hFFFF_FFFA); brd(adr(1, BW - 1), d);
    chk(d == 32'h8, "R7 only I kept", d, 8);
    repeat (10) @(negedge clk);
    chk(got_n == 0 && irq_cnt == 0, "R7 nothing started", {got_n, irq_cnt}, 0);
    // R8/R6 busy write ignored
    fill(0, 8); ready_mode = 2;
    start(0, 8, 1, 0);
    repeat (3) @(negedge clk);
    brd(adr(0, BW - 1), d); chk(d == 32'h9, "R6 S set while busy", d, 9);
    bwr(adr(0, BW - 1), 32'h3); bwr(adr(0, BW - 1), 32'h0);
    brd(adr(0, BW - 1), d); chk(d == 32'h9, "R8 busy write ignored", d, 9);
    ready_mode = 1;
    wait_idle(0);
    chk(station_mac == MRST, "R8 mac untouched", station_mac, MRST);
    brd(adr(0, BW - 1), d); chk(d == 32'h8, "R6 I kept", d, 8);
    cmp_frames("R4 directed");
    // R10 zero length
    start(1, 0, 1, 0); wait_idle(1); cmp_frames("R10 zero length");
    // R9 gating
    bwr(adr(0, BW - 2), 0); gie_m = 0;
    fill(0, 4); start(0, 4, 1, 0); wait_idle(0); cmp_frames("R9 gie off");
    bwr(adr(0, BW - 2), 32'h8000_0000); gie_m = 1;
    fill(1, 5); start(1, 5, 0, 0); wait_idle(1); cmp_frames("R9 I off");
    // R5 address load
    fill(1, 8); start(1, 0, 1, 1); wait_idle(1);
    m = {sh[1][0], sh[1][1], sh[1][2], sh[1][3], sh[1][4], sh[1][5]};
    chk(station_mac == m, "R5 mac load", station_mac, m);
    cmp_frames("R5 no stream");
    // R11 queued second buffer
    fill(0, MAXB); fill(1, 9); ready_mode = 1;
    start(0, MAXB, 1, 0); start(1, 9, 1, 0);
    wait_idle(0); wait_idle(1); cmp_frames("R11 back-to-back");
    // random mix
    for (int it = 0; it < 40; it++) begin
      bit b, iv, prog;
      int len;
      b = 1'($urandom); iv = 1'($urandom); prog = ($urandom % 5) == 0;
      len = $urandom % (MAXB + 1);
      ready_mode = $urandom % 2;
      if ($urandom % 6 == 0) begin
        gie_m = ~gie_m; bwr(adr(0, BW - 2), {gie_m, 31'b0});
      end
      fill(b, prog ? 8 : (len == 0 ? 1 : len));
      start(b, prog ? 0 : len, iv, prog);
      wait_idle(b);
      if (prog) begin
        m = {sh[b][0], sh[b][1], sh[b][2], sh[b][3], sh[b][4], sh[b][5]};
        chk(station_mac == m, "R5 random mac", station_mac, m);
      end
      cmp_frames("R4 random");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule